// File: doc/BRIEF.md
# SPI Serial EEPROM Slave with Block Protection

This block answers an SPI master as a byte-wide serial EEPROM would. The bus pins are chip select (active low), SCK, SI and SO, plus a pause input and a status-freeze input. All of them are resynchronised into the system clock domain. Edges of SCK are found by oversampling, so SCK must run well below the system clock: at least three system cycles per SCK phase. The storage array is an internal RAM of `2**ADDR_W` bytes. The default is small enough to elaborate quickly; a 16 K-byte part uses `ADDR_W = 14`. The address field on the bus is always 16 bits wide, and the bits above `ADDR_W` are ignored.

The block decodes six opcodes: 0x06 sets the write enable latch (WEL), 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads data and 0x02 writes a page. Page data is collected in a page buffer while chip select is low. It is committed only when chip select rises on a byte boundary. The commit starts a self-timed write cycle of `WR_CYCLES` system clocks. During that cycle the buffered bytes are copied into the array, and only the status read is honoured. A two-bit protect field in the status register write-locks the upper part of the array. The WP input freezes that field.

Top module: `eep_spi_slave`

## Requirements
- R1: After reset the status register reads 0x00, and so_en is low whenever chip select is high.
- R2: Opcode 0x06 sets WEL and opcode 0x04 clears it, as seen in status bit 1.
- R3: Opcode 0x05 returns the status byte {4'b0, protect[1:0] in bits 3:2, WEL in bit 1, write-in-progress in bit 0}, repeated for as long as SCK runs.
- R4: Opcode 0x03 followed by a 16-bit address streams bytes from consecutive addresses. Address bits above ADDR_W are ignored, and the stream wraps from the last address to 0.
- R5: Opcode 0x02 followed by a 16-bit address stores the following bytes (up to 32) at consecutive addresses. Bytes past the end of the 32-byte page wrap to the start of the same page.
- R6: A page write or status write issued while WEL is 0 changes nothing and starts no write cycle.
- R7: A write starts only if chip select rises after at least one data byte and on a whole byte. Otherwise the array is untouched, no cycle starts and WEL stays set.
- R8: Each accepted write holds status bit 0 high for WR_CYCLES clocks. WEL clears on the same clock that bit 0 clears.
- R9: While a write cycle runs, every opcode except 0x05 is ignored, including 0x06.
- R10: The protect field locks nothing (0), the top quarter (1), the top half (2) or the whole array (3). Bytes written to a locked address are discarded, and bytes to unlocked addresses in the same page are still stored.
- R11: Opcode 0x01 loads the protect field from data bits 3:2. While wp_n is low the status write is ignored: the field is unchanged, no cycle starts and WEL is kept. Array writes are still allowed.
- R12: While hold_n is low with chip select low, so_en is low and SCK and SI are ignored. The transfer resumes where it paused once hold_n returns high.
- R13: SPI modes 0 and 3 both work. SI is sampled on rising SCK and SO changes after falling SCK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Status write freeze, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Output enable for SO; low means the pin floats |

## Verification
Two events can fall on the same clock: the end of a write cycle and the loading of a status byte into the shift register. At that clock both write-in-progress and WEL change. To provoke this, the bench starts a page write and then, without waiting, issues one long status read. The stream runs well past WR_CYCLES. Every streamed byte must be either the busy value (bits 1:0 = 11) or the idle value (bits 1:0 = 00), never a mixture. The stream must also switch from busy to idle exactly once. A second overlap, a WEL-set opcode arriving mid-cycle, is judged by reading status after the cycle ends.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_AHI,
        PH_ALO,
        PH_DATA,
        PH_SKIP
    } phase_e;

    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [7:0] OP_RD_DATA = 8'h03;
    localparam logic [7:0] OP_WR_PAGE = 8'h02;

    // top = two most significant address bits
    function automatic logic in_locked(input logic [1:0] prot, input logic [1:0] top);
        case (prot)
            2'd0:    return 1'b0;
            2'd1:    return top == 2'b11;
            2'd2:    return top[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q, cnt_d;
    logic          busy_q, busy_d;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (start) begin
            cnt_d  = CW'(CYCLES - 1);
            busy_d = 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_d = 1'b0;
            else             cnt_d  = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 2 ** AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_spi_slave.sv
module eep_spi_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_en
);
    localparam int PW     = $clog2(PAGE_BYTES);
    localparam int SYNC_W = 5;

    typedef struct packed {
        phase_e                         phase;
        logic [2:0]                     bitcnt;
        logic [7:0]                     shreg;
        logic [7:0]                     op;
        logic [7:0]                     ahi;
        logic [7:0]                     tx;
        logic [7:0]                     srnew;
        logic [ADDR_W-1:0]              addr;
        logic                           so;
        logic                           wel;
        logic                           got;
        logic                           flush;
        logic                           sck_p;
        logic                           csn_p;
        logic [1:0]                     bp;
        logic [PW-1:0]                  fidx;
        logic [PAGE_BYTES-1:0]          pval;
        logic [PAGE_BYTES-1:0][7:0]     pbuf;
    } st_t;

    st_t st_q, st_d;

    // synchronised pins: {cs_n, sck, si, hold_n, wp_n}
    logic [SYNC_W-1:0] syn;
    logic csn_s, sck_s, si_s, hold_s, wp_s;

    eep_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL(5'b10011)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si, hold_n, wp_n}),
        .q     (syn)
    );
    assign {csn_s, sck_s, si_s, hold_s, wp_s} = syn;

    logic start, busy, done;
    eep_wtimer #(.CYCLES(WR_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr, rd_addr;
    logic [7:0]        ram_wdata, rdata;
    logic [7:0]        byte_v, status;
    logic              run, sck_rise, sck_fall, csn_rise, csn_fall;

    assign run      = !csn_s && hold_s;
    assign sck_rise = sck_s && !st_q.sck_p;
    assign sck_fall = !sck_s && st_q.sck_p;
    assign csn_rise = csn_s && !st_q.csn_p;
    assign csn_fall = !csn_s && st_q.csn_p;
    assign byte_v   = {st_q.shreg[6:0], si_s};
    assign status   = {4'b0000, st_q.bp, st_q.wel, busy};
    assign rd_addr  = (st_q.phase == PH_ALO) ? ADDR_W'({st_q.ahi, byte_v}) : st_q.addr;
    assign ram_waddr = {st_q.addr[ADDR_W-1:PW], st_q.fidx};
    assign ram_wdata = st_q.pbuf[st_q.fidx];

    eep_ram #(.AW(ADDR_W), .DW(8)) i_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    always_comb begin
        st_d       = st_q;
        start      = 1'b0;
        ram_we     = 1'b0;
        st_d.sck_p = sck_s;
        st_d.csn_p = csn_s;

        // serial input on rising SCK
        if (run && sck_rise) begin
            st_d.shreg  = byte_v;
            st_d.bitcnt = st_q.bitcnt + 3'd1;
            if (st_q.bitcnt == 3'd7) begin
                unique case (st_q.phase)
                    PH_CMD: begin
                        st_d.op    = byte_v;
                        st_d.phase = PH_SKIP;
                        st_d.got   = 1'b0;
                        if (byte_v == OP_RD_STAT) begin
                            st_d.phase = PH_DATA;
                            st_d.tx    = status;
                        end else if (!busy) begin
                            case (byte_v)
                                OP_SET_WEL: st_d.wel   = 1'b1;
                                OP_CLR_WEL: st_d.wel   = 1'b0;
                                OP_WR_STAT: st_d.phase = PH_DATA;
                                OP_RD_DATA: st_d.phase = PH_AHI;
                                OP_WR_PAGE: begin
                                    st_d.phase = PH_AHI;
                                    st_d.pval  = '0;
                                end
                                default: ;
                            endcase
                        end
                    end
                    PH_AHI: begin
                        st_d.ahi   = byte_v;
                        st_d.phase = PH_ALO;
                    end
                    PH_ALO: begin
                        st_d.phase = PH_DATA;
                        st_d.addr  = rd_addr;
                        if (st_q.op == OP_RD_DATA) begin
                            st_d.tx   = rdata;
                            st_d.addr = rd_addr + ADDR_W'(1);
                        end
                    end
                    PH_DATA: begin
                        case (st_q.op)
                            OP_RD_STAT: st_d.tx = status;
                            OP_RD_DATA: begin
                                st_d.tx   = rdata;
                                st_d.addr = st_q.addr + ADDR_W'(1);
                            end
                            OP_WR_STAT: begin
                                st_d.srnew = byte_v;
                                st_d.got   = 1'b1;
                            end
                            OP_WR_PAGE: begin
                                if (!in_locked(st_q.bp, st_q.addr[ADDR_W-1 -: 2])) begin
                                    st_d.pbuf[st_q.addr[PW-1:0]] = byte_v;
                                    st_d.pval[st_q.addr[PW-1:0]] = 1'b1;
                                end
                                st_d.addr = {st_q.addr[ADDR_W-1:PW], st_q.addr[PW-1:0] + 1'b1};
                                st_d.got  = 1'b1;
                            end
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end

        // serial output on falling SCK
        if (run && sck_fall) begin
            st_d.so = st_q.tx[7];
            st_d.tx = {st_q.tx[6:0], 1'b0};
        end

        if (csn_fall) begin
            st_d.phase  = PH_CMD;
            st_d.bitcnt = '0;
            st_d.got    = 1'b0;
        end

        // commit on deselect
        if (csn_rise) begin
            if (st_q.phase == PH_DATA && st_q.got && st_q.bitcnt == 3'd0 &&
                st_q.wel && !busy) begin
                if (st_q.op == OP_WR_PAGE) begin
                    start      = 1'b1;
                    st_d.flush = 1'b1;
                    st_d.fidx  = '0;
                end else if (st_q.op == OP_WR_STAT && wp_s) begin
                    start   = 1'b1;
                    st_d.bp = st_q.srnew[3:2];
                end
            end
            st_d.phase  = PH_SKIP;
            st_d.bitcnt = '0;
        end

        // copy page buffer into the array during the cycle
        if (st_q.flush) begin
            ram_we    = st_q.pval[st_q.fidx];
            st_d.fidx = st_q.fidx + 1'b1;
            if (st_q.fidx == PW'(PAGE_BYTES - 1)) st_d.flush = 1'b0;
        end

        if (done) st_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.csn_p <= 1'b1;
            st_q.phase <= PH_SKIP;
        end else begin
            st_q <= st_d;
        end
    end

    assign so    = st_q.so;
    assign so_en = !csn_s && hold_s;

    // named views for the bound checker
    logic       wel_w;
    logic [1:0] bp_w;
    logic [2:0] bitcnt_w;
    assign wel_w    = st_q.wel;
    assign bp_w     = st_q.bp;
    assign bitcnt_w = st_q.bitcnt;
endmodule

// File: rtl/eep_chk.sv
module eep_chk
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       wp_s,
    input logic       hold_s,
    input logic       csn_s,
    input logic [2:0] bitcnt,
    input logic       ram_we,
    input logic [1:0] waddr_top
);
    AST_WEL_DROPS_WITH_WIP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);                                   // R8
    AST_ARRAY_WRITE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);                                        // R8
    AST_NO_WEL_SET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !$rose(wel));                                   // R9
    AST_LOCKED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !in_locked(bp, waddr_top));                   // R10
    AST_PROT_FROZEN_WP: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_s |=> $stable(bp));                                  // R11
    AST_HOLD_FREEZES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_s && !csn_s) |=> $stable(bitcnt));                // R12
endmodule

bind eep_spi_slave eep_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .wel       (wel_w),
    .bp        (bp_w),
    .wp_s      (wp_s),
    .hold_s    (hold_s),
    .csn_s     (csn_s),
    .bitcnt    (bitcnt_w),
    .ram_we    (ram_we),
    .waddr_top (ram_waddr[ADDR_W-1 -: 2])
);

// File: tb/test_eep_spi_slave.sv
module test_eep_spi_slave;
    localparam int AW   = 11;
    localparam int SIZE = 2 ** AW;
    localparam int PB   = 32;
    localparam int WRC  = 400;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_en;

    always #5 clk = ~clk;

    eep_spi_slave #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) i_eep_spi_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_en(so_en)
    );

    int n_chk = 0, n_fail = 0;
    logic [7:0] mdl [SIZE];
    bit         kn  [SIZE];
    logic [1:0] m_bp = 2'd0;
    bit m_wel = 0, m_busy = 0, mode3 = 0;
    logic [7:0] tb_tx [0:39];
    logic [7:0] tb_rx [0:39];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_locked(input logic [1:0] p, input int a);
        case (p)
            2'd0:    return 0;
            2'd1:    return a >= (SIZE * 3) / 4;
            2'd2:    return a >= SIZE / 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] exp_sr(input bit wip);
        return {4'b0000, m_bp, m_wel, wip};
    endfunction

    task automatic do_hold();
        repeat (HALF) @(posedge clk);
        @(negedge clk) hold_n = 1'b0;
        repeat (HALF) @(posedge clk);
        @(negedge clk);
        check(so_en == 1'b0, "R12 so_en during hold", so_en, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) begin sck = 1'b1; si = $urandom; end
            repeat (HALF) @(posedge clk);
            @(negedge clk) sck = 1'b0;
            repeat (HALF) @(posedge clk);
        end
        @(negedge clk) hold_n = 1'b1;
        repeat (HALF) @(posedge clk);
    endtask

    task automatic xfer(input int nbits, input int hold_at);
        @(negedge clk) sck = mode3;
        repeat (HALF) @(posedge clk);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk) sck = 1'b0;
            if (b == hold_at) do_hold();
            @(negedge clk) si = tb_tx[b/8][7 - b%8];
            repeat (HALF) @(posedge clk);
            @(negedge clk) begin tb_rx[b/8][7 - b%8] = so; sck = 1'b1; end
            repeat (HALF) @(posedge clk);
        end
        @(negedge clk) sck = mode3;
        repeat (HALF) @(posedge clk);
        @(negedge clk) cs_n = 1'b1;
        repeat (2 * HALF) @(posedge clk);
    endtask

    task automatic wait_idle();
        if (m_busy) begin
            repeat (WRC + 20) @(posedge clk);
            m_busy = 0;
            m_wel  = 0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        tb_tx[0] = op;
        xfer(8, -1);
        if (!m_busy && op == 8'h06) m_wel = 1;
        if (!m_busy && op == 8'h04) m_wel = 0;
    endtask

    task automatic rdsr(input int n);
        tb_tx[0] = 8'h05;
        for (int i = 1; i <= n; i++) tb_tx[i] = 8'h00;
        xfer(8 * (1 + n), -1);
    endtask

    task automatic chk_sr(input string req, input bit wip);
        rdsr(2);
        check(tb_rx[1] == exp_sr(wip), req, tb_rx[1], exp_sr(wip));
        check(tb_rx[2] == exp_sr(wip), "R3 status repeats", tb_rx[2], exp_sr(wip));
    endtask

    task automatic wrsr(input logic [7:0] v);
        tb_tx[0] = 8'h01;
        tb_tx[1] = v;
        xfer(16, -1);
        if (m_wel && !m_busy && wp_n) begin
            m_bp   = v[3:2];
            m_busy = 1;
        end
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) tb_tx[3+i] = 8'($urandom);
    endtask

    task automatic wr_page(input int addr, input int n, input int extra, input bit wait_end);
        int base, a, off;
        tb_tx[0] = 8'h02;
        tb_tx[1] = addr[15:8];
        tb_tx[2] = addr[7:0];
        xfer(8 * (3 + n) + extra, -1);
        if (m_wel && !m_busy && n > 0 && extra == 0) begin
            base = (addr % SIZE) - ((addr % SIZE) % PB);
            off  = (addr % SIZE) % PB;
            for (int i = 0; i < n; i++) begin
                a = base + ((off + i) % PB);
                if (!exp_locked(m_bp, a)) begin
                    mdl[a] = tb_tx[3+i];
                    kn[a]  = 1;
                end
            end
            m_busy = 1;
        end
        if (wait_end) wait_idle();
    endtask

    task automatic rd(input int addr, input int n, input int hold_at, input string req);
        int a;
        tb_tx[0] = 8'h03;
        tb_tx[1] = addr[15:8];
        tb_tx[2] = addr[7:0];
        for (int i = 0; i < n; i++) tb_tx[3+i] = 8'h00;
        xfer(8 * (3 + n), hold_at);
        for (int i = 0; i < n; i++) begin
            a = (addr + i) % SIZE;
            if (kn[a]) check(tb_rx[3+i] == mdl[a], req, tb_rx[3+i], mdl[a]);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        finish_run();
    end

    initial begin
        bit seen_idle;
        logic [7:0] busy_v, idle_v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < SIZE; i++) kn[i] = 0;
        repeat (10) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(so_en == 1'b0, "R1 so_en deselected", so_en, 0);
        chk_sr("R1 reset status", 0);

        // R2 latch set / clear
        cmd1(8'h06); chk_sr("R2 WEL set", 0);
        cmd1(8'h04); chk_sr("R2 WEL clear", 0);

        // R5, R8 basic page write
        cmd1(8'h06); fill(4); wr_page(16'h0010, 4, 0, 0);
        chk_sr("R8 busy status", 1);
        wait_idle();
        chk_sr("R8 WEL cleared at end", 0);
        rd(16'h0010, 4, -1, "R5 page data");

        // R6 no WEL
        fill(4); wr_page(16'h0010, 4, 0, 1);
        chk_sr("R6 no cycle without WEL", 0);
        rd(16'h0010, 4, -1, "R6 array unchanged");

        // R9 WREN during busy ignored
        cmd1(8'h06); fill(3); wr_page(16'h0100, 3, 0, 0);
        cmd1(8'h06);
        wait_idle();
        chk_sr("R9 WREN ignored while busy", 0);
        rd(16'h0100, 3, -1, "R5 second page");

        // R5 page wrap
        cmd1(8'h06); fill(5); wr_page(16'h0040 + 30, 5, 0, 1);
        rd(16'h0040, 32, -1, "R5 wrap within page");

        // R7 partial byte and zero data bytes
        cmd1(8'h06); fill(2); wr_page(16'h0100, 2, 3, 0);
        chk_sr("R7 partial byte no cycle", 0);
        rd(16'h0100, 3, -1, "R7 array unchanged");
        wr_page(16'h0100, 0, 0, 0);
        chk_sr("R7 no data byte no cycle", 0);
        cmd1(8'h04);

        // R4 upper address bits ignored, wrap to 0
        rd(16'hF810, 4, -1, "R4 upper bits ignored");
        cmd1(8'h06); fill(2); wr_page(SIZE - 2, 2, 0, 1);
        cmd1(8'h06); fill(2); wr_page(0, 2, 0, 1);
        rd(SIZE - 2, 4, -1, "R4 wrap last to 0");

        // R10, R11 protection levels
        for (int p = 1; p < 4; p++) begin
            cmd1(8'h06); wrsr(8'(p << 2)); wait_idle();
            chk_sr("R11 protect field", 0);
            cmd1(8'h06); fill(4); wr_page(SIZE - 64, 4, 0, 1);
            cmd1(8'h06); fill(4); wr_page(SIZE / 2 + 32, 4, 0, 1);
            cmd1(8'h06); fill(4); wr_page(16'h0100, 4, 0, 1);
            rd(SIZE - 64, 4, -1, "R10 top quarter");
            rd(SIZE / 2 + 32, 4, -1, "R10 upper half");
            rd(16'h0100, 4, -1, "R10 low region");
        end

        // R11 WP freezes status, not array
        @(negedge clk) wp_n = 1'b0;
        cmd1(8'h06); wrsr(8'h00);
        chk_sr("R11 status write ignored with WP low", 0);
        wp_n = 1'b1;
        wrsr(8'h00); wait_idle();
        chk_sr("R11 status written with WP high", 0);
        @(negedge clk) wp_n = 1'b0;
        cmd1(8'h06); fill(4); wr_page(16'h0300, 4, 0, 1);
        rd(16'h0300, 4, -1, "R11 array write with WP low");
        @(negedge clk) wp_n = 1'b1;

        // R12, R13 hold in both modes
        mode3 = 0; rd(16'h0040, 8, 30, "R12 hold resume mode 0");
        mode3 = 1; rd(16'h0040, 8, 45, "R12 hold resume mode 3");
        chk_sr("R13 status in mode 3", 0);

        // overlap: status stream across end of write cycle
        mode3 = 0;
        cmd1(8'h06); fill(2); wr_page(16'h0200, 2, 0, 0);
        busy_v = exp_sr(1);
        rdsr(8);
        m_busy = 0; m_wel = 0;
        idle_v = exp_sr(0);
        check(tb_rx[1] == busy_v, "R8 first streamed byte busy", tb_rx[1], busy_v);
        check(tb_rx[8] == idle_v, "R8 last streamed byte idle", tb_rx[8], idle_v);
        seen_idle = 0;
        for (int i = 1; i <= 8; i++) begin
            check(tb_rx[i] == busy_v || tb_rx[i] == idle_v, "R8 WIP and WEL fall together",
                  tb_rx[i], seen_idle ? idle_v : busy_v);
            if (seen_idle)
                check(tb_rx[i] == idle_v, "R8 idle stays idle", tb_rx[i], idle_v);
            if (tb_rx[i] == idle_v) seen_idle = 1;
        end
        rd(16'h0200, 2, -1, "R5 overlap page data");

        // R13 random mix of modes, addresses and lengths
        for (int it = 0; it < 12; it++) begin
            int a, n;
            mode3 = $urandom_range(0, 1);
            a = $urandom_range(0, 16'hFFFF);
            n = $urandom_range(1, 16);
            cmd1(8'h06); fill(n); wr_page(a, n, 0, 1);
            rd(a - (a % PB), PB, -1, "R13 random page readback");
        end

        finish_run();
    end
endmodule